// File: doc/BRIEF.md
# Dual-Channel Converter Output Mode Controller

This block sits behind the two conversion cores of a dual in-phase/quadrature sampler and owns everything the cores put on their digital output buses. Each clock, each channel hands it one raw sample word in offset-binary form. The block registers that word onto the channel's output bus, optionally flipping it to two's complement. It also raises a per-channel valid flag once the channel has run long enough to be trusted.

A two-bit mode pin selects which channels run and whether the quadrature output is shifted by half a clock. A format pin chooses the number format. Both pins are asynchronous, so each channel's clock domain synchronizes them before use.

A stopped channel keeps driving its last word. Each channel is held by a three-state machine:

- `CH_SLEEP`: standby, bus frozen, flag low.
- `CH_WARM`: running, flag low, warm-up count advancing.
- `CH_LIVE`: running, flag high.

The transitions are:

- `CH_SLEEP` to `CH_WARM` when the synchronized mode says the channel runs.
- `CH_WARM` to `CH_LIVE` when the warm-up count completes.
- `CH_WARM` or `CH_LIVE` to `CH_SLEEP` whenever the synchronized mode says the channel stops.

Reset leaves every channel in `CH_SLEEP`.

Top module: `adc_out_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it, both output buses read 0 and both valid flags are low.
- R2: `mode_sel` encodes the following: 00 puts both channels in standby; 01 runs the I channel and keeps Q in standby; 10 runs both channels with their outputs changing on the same rising edge; 11 runs both channels with Q retimed by half a clock.
- R3: A channel in standby keeps driving the last word it captured. Changes on its raw input or on `fmt_twos` do not alter its output bus.
- R4: A channel's valid flag is low in standby. It rises only after the 20th consecutive rising edge at which that channel is seen running. Any entry into standby, including one during warm-up, restarts the count from zero.
- R5: `mode_sel` and `fmt_twos` pass through a two-flop synchronizer in each channel's clock domain. A mode change applied before rising edge 0 is first acted on at edge 2. After power-up or a standby exit, the valid flag is therefore still low after edge 20 and high after edge 21.
- R6: With `fmt_twos` low the captured word equals the raw word (offset binary). With it high, bit 9 (the MSB) is inverted and all other bits pass unchanged (two's complement).
- R7: A running channel, valid or still warming up, captures on each rising edge. After the edge its bus shows the formatted raw word that was present before that edge.
- R8: In mode 11, the Q bus changes on the falling edge half a clock after the rising edge that captured the word. The I bus still changes on the rising edge, and switching between modes 10 and 11 does not restart Q's warm-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I channel clock |
| clk_q | input | 1 | Q channel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Asynchronous mode select (standby / I only / aligned / Q half-cycle) |
| fmt_twos | input | 1 | Asynchronous format select: 0 offset binary, 1 two's complement |
| raw_i | input | 10 | Raw offset-binary word from the I core |
| raw_q | input | 10 | Raw offset-binary word from the Q core |
| dout_i | output | 10 | Registered I output bus |
| dout_q | output | 10 | Registered Q output bus |
| vld_i | output | 1 | I data valid |
| vld_q | output | 1 | Q data valid |

## Verification
A warm-up counter that is off by one, or that fails to restart, shows up as the valid flag rising one edge early or late. It can also rise well before edge 21 after an interrupted warm-up, and so becomes visible within 22 clocks of a mode change. A channel machine stuck in a running state shows as a bus that follows raw input during standby on the third edge after the pin change. A wrong format bit, or a Q word captured on the wrong edge, is visible on the very next edge, or on the next falling edge in the half-cycle mode.

// File: rtl/adcmc_pkg.sv
package adcmc_pkg;

    typedef enum logic [1:0] {
        CH_SLEEP = 2'd0,
        CH_WARM  = 2'd1,
        CH_LIVE  = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        MD_STANDBY    = 2'b00,
        MD_I_ONLY     = 2'b01,
        MD_IQ_ALIGNED = 2'b10,
        MD_IQ_HALF    = 2'b11
    } mode_e;

    // I channel runs in every mode except full standby
    function automatic logic mode_runs_i(input logic [1:0] m);
        logic r;
        unique case (mode_e'(m))
            MD_STANDBY:    r = 1'b0;
            MD_I_ONLY:     r = 1'b1;
            MD_IQ_ALIGNED: r = 1'b1;
            MD_IQ_HALF:    r = 1'b1;
            default:       r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic mode_runs_q(input logic [1:0] m);
        logic r;
        unique case (mode_e'(m))
            MD_STANDBY:    r = 1'b0;
            MD_I_ONLY:     r = 1'b0;
            MD_IQ_ALIGNED: r = 1'b1;
            MD_IQ_HALF:    r = 1'b1;
            default:       r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic mode_q_half(input logic [1:0] m);
        return (mode_e'(m) == MD_IQ_HALF);
    endfunction

endpackage

// File: rtl/adcmc_sync.sv
module adcmc_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/adcmc_chan.sv
module adcmc_chan
    import adcmc_pkg::*;
#(
    parameter int DW          = 10,
    parameter int WARM_CYCLES = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          twos,
    input  logic [DW-1:0] raw,
    output logic [DW-1:0] dout,
    output logic          vld
);
    localparam int CW = $clog2(WARM_CYCLES + 1);
    localparam logic [DW-1:0] SIGN_FLIP = {1'b1, {(DW-1){1'b0}}};
    localparam logic [CW-1:0] LAST_CNT  = CW'(WARM_CYCLES - 1);

    ch_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [DW-1:0] word_q;

    // next-state and warm-up count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CH_SLEEP: begin
                if (run) begin
                    cnt_d   = CW'(1);
                    state_d = (WARM_CYCLES <= 1) ? CH_LIVE : CH_WARM;
                end
            end
            CH_WARM: begin
                if (!run) begin
                    state_d = CH_SLEEP;
                    cnt_d   = '0;
                end else if (cnt_q >= LAST_CNT) begin
                    state_d = CH_LIVE;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            CH_LIVE: begin
                if (!run) begin
                    state_d = CH_SLEEP;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = CH_SLEEP;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_SLEEP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output register: capture while running, freeze in standby
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   word_q <= '0;
        else if (run) word_q <= twos ? (raw ^ SIGN_FLIP) : raw;
    end

    assign dout = word_q;
    assign vld  = (state_q == CH_LIVE);
endmodule

// File: rtl/adcmc_halfcyc.sv
module adcmc_halfcyc #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_half,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    logic [DW-1:0] fall_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= d;
    end

    assign q = en_half ? fall_q : d;
endmodule

// File: rtl/adc_out_ctrl.sv
module adc_out_ctrl
    import adcmc_pkg::*;
#(
    parameter int DW          = 10,
    parameter int WARM_CYCLES = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_i,
    input  logic          clk_q,
    input  logic          rst_n,
    input  logic [1:0]    mode_sel,
    input  logic          fmt_twos,
    input  logic [DW-1:0] raw_i,
    input  logic [DW-1:0] raw_q,
    output logic [DW-1:0] dout_i,
    output logic [DW-1:0] dout_q,
    output logic          vld_i,
    output logic          vld_q
);
    localparam int CTLW = 3;

    logic [CTLW-1:0] ctl_i_s, ctl_q_s;
    logic            i_run_s, i_fmt_s;
    logic            q_run_s, q_fmt_s, q_half_s;
    logic [DW-1:0]   q_word;

    adcmc_sync #(.W(CTLW), .STAGES(SYNC_STAGES)) u_sync_i (
        .clk(clk_i), .rst_n(rst_n), .d({fmt_twos, mode_sel}), .q(ctl_i_s)
    );
    adcmc_sync #(.W(CTLW), .STAGES(SYNC_STAGES)) u_sync_q (
        .clk(clk_q), .rst_n(rst_n), .d({fmt_twos, mode_sel}), .q(ctl_q_s)
    );

    assign i_run_s  = mode_runs_i(ctl_i_s[1:0]);
    assign i_fmt_s  = ctl_i_s[2];
    assign q_run_s  = mode_runs_q(ctl_q_s[1:0]);
    assign q_half_s = mode_q_half(ctl_q_s[1:0]);
    assign q_fmt_s  = ctl_q_s[2];

    adcmc_chan #(.DW(DW), .WARM_CYCLES(WARM_CYCLES)) u_chan_i (
        .clk(clk_i), .rst_n(rst_n), .run(i_run_s), .twos(i_fmt_s),
        .raw(raw_i), .dout(dout_i), .vld(vld_i)
    );

    adcmc_chan #(.DW(DW), .WARM_CYCLES(WARM_CYCLES)) u_chan_q (
        .clk(clk_q), .rst_n(rst_n), .run(q_run_s), .twos(q_fmt_s),
        .raw(raw_q), .dout(q_word), .vld(vld_q)
    );

    adcmc_halfcyc #(.DW(DW)) u_half_q (
        .clk(clk_q), .rst_n(rst_n), .en_half(q_half_s), .d(q_word), .q(dout_q)
    );
endmodule

// File: rtl/adc_out_ctrl_chk.sv
module adc_out_ctrl_chk #(
    parameter int DW          = 10,
    parameter int WARM_CYCLES = 20
) (
    input logic          clk_i,
    input logic          clk_q,
    input logic          rst_n,
    input logic [DW-1:0] raw_i,
    input logic [DW-1:0] dout_i,
    input logic [DW-1:0] dout_q,
    input logic          vld_i,
    input logic          vld_q,
    input logic          i_run_s,
    input logic          i_fmt_s,
    input logic          q_run_s
);
    localparam int WCW = $clog2(WARM_CYCLES + 1);
    localparam logic [WCW-1:0] WFULL = WCW'(WARM_CYCLES);
    localparam logic [DW-1:0] TOP_BIT = {1'b1, {(DW-1){1'b0}}};

    logic [WCW-1:0] run_len_i;

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n)                  run_len_i <= '0;
        else if (!i_run_s)           run_len_i <= '0;
        else if (run_len_i < WFULL)  run_len_i <= run_len_i + WCW'(1);
    end

    AST_I_STANDBY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
        !i_run_s |=> $stable(dout_i)); // R3
    AST_Q_STANDBY_HOLD: assert property (@(posedge clk_q) disable iff (!rst_n)
        !q_run_s |=> $stable(dout_q)); // R3
    AST_I_VLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_n)
        !i_run_s |=> !vld_i); // R4
    AST_Q_VLD_OFF: assert property (@(posedge clk_q) disable iff (!rst_n)
        !q_run_s |=> !vld_q); // R4
    AST_I_WARM_MIN: assert property (@(posedge clk_i) disable iff (!rst_n)
        vld_i |-> (run_len_i >= WFULL)); // R4
    AST_I_VLD_DUE: assert property (@(posedge clk_i) disable iff (!rst_n)
        (run_len_i == WFULL) |-> vld_i); // R4
    AST_I_PASS: assert property (@(posedge clk_i) disable iff (!rst_n)
        (i_run_s && !i_fmt_s) |=> (dout_i == $past(raw_i))); // R7
    AST_I_TWOS: assert property (@(posedge clk_i) disable iff (!rst_n)
        (i_run_s && i_fmt_s) |=> (dout_i == ($past(raw_i) ^ TOP_BIT))); // R6
endmodule

bind adc_out_ctrl adc_out_ctrl_chk #(.DW(DW), .WARM_CYCLES(WARM_CYCLES)) u_chk (.*);

// File: tb/sim_adc_out_ctrl.sv
`timescale 1ns/1ps
module sim_adc_out_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode;
    logic       fmt;
    logic [9:0] raw_i, raw_q;
    logic [9:0] dout_i, dout_q;
    logic       vld_i, vld_q;
    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    adc_out_ctrl u0 (
        .clk_i(clk), .clk_q(clk), .rst_n(rst_n), .mode_sel(mode), .fmt_twos(fmt),
        .raw_i(raw_i), .raw_q(raw_q), .dout_i(dout_i), .dout_q(dout_q),
        .vld_i(vld_i), .vld_q(vld_q)
    );

    // {fmt, raw_i, raw_q, exp_i, exp_q}
    localparam logic [40:0] VEC [6] = '{
        {1'b0, 10'h3FF, 10'h000, 10'h3FF, 10'h000},
        {1'b0, 10'h155, 10'h2AA, 10'h155, 10'h2AA},
        {1'b1, 10'h200, 10'h3FF, 10'h000, 10'h1FF},
        {1'b1, 10'h000, 10'h1FF, 10'h200, 10'h3FF},
        {1'b1, 10'h2AA, 10'h155, 10'h0AA, 10'h355},
        {1'b0, 10'h001, 10'h200, 10'h001, 10'h200}
    };

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input string tag, input int act, input int exp_v);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp_v);
        end
    endtask

    initial begin
        #4000000;
        total++;
        bad++;
        $display("FAIL watchdog R1..: act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode = 2'b10; fmt = 1'b0; raw_i = '0; raw_q = '0;
        repeat (3) step();
        chk("R1 dout_i", dout_i, 0);
        chk("R1 dout_q", dout_q, 0);
        chk("R1 vld_i", vld_i, 0);
        chk("R1 vld_q", vld_q, 0);
        rst_n = 1'b1;

        // power-up warm-up: low after edge 20, high after edge 21
        repeat (21) step();
        chk("R5 vld_i edge20", vld_i, 0);
        chk("R5 vld_q edge20", vld_q, 0);
        step();
        chk("R4 vld_i edge21", vld_i, 1);
        chk("R4 vld_q edge21", vld_q, 1);

        // format table, mode 10
        for (int k = 0; k < 6; k++) begin
            fmt   = VEC[k][40];
            raw_i = VEC[k][39:30];
            raw_q = VEC[k][29:20];
            repeat (4) step();
            chk("R6 dout_i", dout_i, int'(VEC[k][19:10]));
            chk("R2 R6 dout_q", dout_q, int'(VEC[k][9:0]));
        end

        // one-cycle latency
        raw_i = 10'h0F0; raw_q = 10'h30C;
        step();
        chk("R7 dout_i", dout_i, 10'h0F0);
        chk("R7 dout_q", dout_q, 10'h30C);

        // Q half-cycle mode
        mode = 2'b11;
        repeat (4) step();
        raw_i = 10'h11B; raw_q = 10'h2E4;
        step();
        chk("R8 dout_i rise", dout_i, 10'h11B);
        chk("R8 dout_q before fall", dout_q, 10'h30C);
        chk("R8 vld_q kept", vld_q, 1);
        #10;
        chk("R8 dout_q after fall", dout_q, 10'h2E4);

        // I only
        mode = 2'b01;
        repeat (4) step();
        raw_q = 10'h3A5; raw_i = 10'h05A;
        repeat (4) step();
        chk("R3 dout_q held", dout_q, 10'h2E4);
        chk("R4 vld_q standby", vld_q, 0);
        chk("R2 dout_i runs", dout_i, 10'h05A);
        chk("R2 vld_i runs", vld_i, 1);

        // both standby, raw and format changes ignored
        mode = 2'b00;
        repeat (4) step();
        raw_i = 10'h3C3; raw_q = 10'h000; fmt = 1'b1;
        repeat (5) step();
        chk("R3 dout_i held", dout_i, 10'h05A);
        chk("R3 dout_q held2", dout_q, 10'h2E4);
        chk("R4 vld_i standby", vld_i, 0);

        // leave standby: fresh warm-up
        mode = 2'b10;
        repeat (21) step();
        chk("R4 vld_i rewarm edge20", vld_i, 0);
        chk("R7 dout_i in warm-up", dout_i, 10'h1C3);
        step();
        chk("R4 vld_i rewarm edge21", vld_i, 1);
        chk("R4 vld_q rewarm edge21", vld_q, 1);
        chk("R6 dout_q twos", dout_q, 10'h200);

        // interrupted warm-up restarts
        mode = 2'b00;
        repeat (4) step();
        mode = 2'b10;
        repeat (10) step();
        mode = 2'b00;
        repeat (3) step();
        mode = 2'b10;
        repeat (21) step();
        chk("R4 restart edge20", vld_i, 0);
        step();
        chk("R4 restart edge21", vld_i, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule